// File: doc/BRIEF.md
# Printer Port Register Block

This block is the host-facing register set of a printer-style parallel port running in compatibility mode. A simple bus with separate read and write strobes reaches a data register, a status register and a control register through a 3-bit offset taken from the low bits of the bus address. Internally the block keeps a byte latch for outgoing data, a byte latch for incoming data, the status byte, the control byte and an interrupt-pending flag.

The printer side is modelled, not wired. Software pulses the strobe bit in the control register, and the outgoing latch leaves the block as one byte on a valid/ready stream. The printer's reply comes from polling: every status read moves the acknowledge/busy pair one step through a fixed sequence. An interrupt line reports the pending flag. A status read clears that flag. A control write that drops the strobe sets it, provided interrupts were enabled beforehand. An incoming byte can be captured into the read latch from a side input. The bus sees that byte when the direction bit selects input.

Top module: `lpt_regif`

## Requirements
- R1: Only address bits [2:0] are decoded: 0 is data, 1 is status, 2 is control. A read of offsets 3 to 7 returns 0xFF. Writes to offset 1 and to offsets 3 to 7 change nothing that can be seen at the ports.
- R2: A write to control stores the written byte with bits 7 and 6 forced to 1. A control read returns the stored byte. Control bit layout: 5 direction, 4 interrupt enable, 3 select, 2 init, 1 auto-linefeed, 0 strobe.
- R3: A control write whose init bit (2) is 0 sets status to 0xD8, which is busy, ack, online and error. Status bit layout: 7 busy, 6 ack, 5 paper-out, 4 online, 3 error, 0 timeout.
- R4: A control write with init 1, select 1 and strobe 1 clears status busy. If the stored strobe bit was 0 before that write, the outgoing data latch is emitted as one stream byte.
- R5: A control write with init 1, select 1 and strobe 0 sets interrupt pending, but only if the previously stored control byte had interrupt enable set. The irq output is a register that takes the new pending value at the edge that completes any data, status or control access.
- R6: A status read returns the status held before the read and clears interrupt pending.
- R7: A status read taken while busy is 0 and stored strobe is 0 also steps the handshake. If ack is 1, ack is cleared. If ack is 0, ack and busy are both set.
- R8: A data read returns the incoming read latch when control direction (bit 5) is 1, and the outgoing write latch otherwise. A data write loads the outgoing latch.
- R9: After reset both data latches are 0xFF, status is 0xD9, control is 0xCC, and pending, irq, stream valid and overflow are 0.
- R10: A stream byte keeps out_valid high and out_data unchanged until it is taken with out_ready. An emission that arrives while a byte is held and not being taken is dropped, and a sticky overflow flag is set.
- R11: A cycle with rx_load high captures rx_byte into the incoming read latch.
- R12: When bus_rd and bus_wr are high in the same cycle, only the write takes effect. The read has no side effects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Bus address; bits [2:0] select the register |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Registered interrupt request |
| rx_load | input | 1 | Capture rx_byte into the incoming read latch |
| rx_byte | input | 8 | Incoming byte |
| out_valid | output | 1 | Stream byte held |
| out_ready | input | 1 | Consumer takes the held byte |
| out_data | output | 8 | Stream byte |
| overflow | output | 1 | Sticky flag: an emission was dropped |

## Verification
A corrupted status byte shows at the ports on the next status read, and a wrong handshake step shows on the read after that. Most faults therefore appear within one or two polls. A stale stored strobe or interrupt-enable bit has a different symptom. It either emits a byte it should not, or suppresses one it should emit, or misses a pending flag. Each of these shows on out_valid or irq at the edge after the control write. Comparing the ports with a reference model on every cycle makes each divergence visible at the first cycle it occurs.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int BYTE_W = 8;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_DATA = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd2;

  // status bits
  localparam int ST_BUSY = 7;
  localparam int ST_ACK  = 6;
  // control bits
  localparam int CT_DIR  = 5;
  localparam int CT_IEN  = 4;
  localparam int CT_SEL  = 3;
  localparam int CT_INIT = 2;
  localparam int CT_STB  = 0;

  localparam logic [BYTE_W-1:0] STAT_RST   = 8'hD9;
  localparam logic [BYTE_W-1:0] STAT_INIT  = 8'hD8;
  localparam logic [BYTE_W-1:0] CTRL_RST   = 8'hCC;
  localparam logic [BYTE_W-1:0] CTRL_FORCE = 8'hC0;
  localparam logic [BYTE_W-1:0] DATA_RST   = 8'hFF;
  localparam logic [BYTE_W-1:0] OPEN_READ  = 8'hFF;

  typedef struct packed {
    logic wr_data;
    logic wr_ctrl;
    logic rd_stat;
    logic any;
  } acc_t;
endpackage

// File: rtl/lpt_decode.sv
module lpt_decode
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic [OFS_W-1:0]  ofs,
  output acc_t              acc
);
  logic rd_eff;
  logic known;

  always_comb begin
    ofs         = addr[OFS_W-1:0];
    rd_eff      = rd & ~wr;
    known       = (ofs == OFS_DATA) | (ofs == OFS_STAT) | (ofs == OFS_CTRL);
    acc.wr_data = wr & (ofs == OFS_DATA);
    acc.wr_ctrl = wr & (ofs == OFS_CTRL);
    acc.rd_stat = rd_eff & (ofs == OFS_STAT);
    acc.any     = (wr | rd_eff) & known;
  end
endmodule

// File: rtl/lpt_ctrl_reg.sv
module lpt_ctrl_reg
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] dataw_q,
  output logic [BYTE_W-1:0] datar_q,
  output logic              emit
);
  logic [BYTE_W-1:0] ctrl_d, dataw_d, datar_d;
  logic              ctrl_en, dataw_en, datar_en;

  always_comb begin
    ctrl_en  = acc.wr_ctrl;
    ctrl_d   = wdata | CTRL_FORCE;
    dataw_en = acc.wr_data;
    dataw_d  = wdata;
    datar_en = rx_load;
    datar_d  = rx_byte;
    emit     = acc.wr_ctrl & wdata[CT_INIT] & wdata[CT_SEL] & wdata[CT_STB]
               & ~ctrl_q[CT_STB];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= CTRL_RST;
      dataw_q <= DATA_RST;
      datar_q <= DATA_RST;
    end else begin
      if (ctrl_en)  ctrl_q  <= ctrl_d;
      if (dataw_en) dataw_q <= dataw_d;
      if (datar_en) datar_q <= datar_d;
    end
  end

  AST_CTRL_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    acc.wr_ctrl |=> ctrl_q == ($past(wdata) | 8'hC0)); // R2
endmodule

// File: rtl/lpt_status_hs.sv
module lpt_status_hs
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  acc_t              acc,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] ctrl_q,
  output logic [BYTE_W-1:0] stat_q,
  output logic              irq_q
);
  logic [BYTE_W-1:0] stat_d;
  logic              pend_q, pend_d, irq_d;
  logic              stat_en;

  always_comb begin
    stat_d = stat_q;
    pend_d = pend_q;
    if (acc.wr_ctrl) begin
      if (!wdata[CT_INIT]) begin
        stat_d = STAT_INIT;
      end else if (wdata[CT_SEL]) begin
        if (wdata[CT_STB])      stat_d[ST_BUSY] = 1'b0;
        else if (ctrl_q[CT_IEN]) pend_d = 1'b1;
      end
    end else if (acc.rd_stat) begin
      pend_d = 1'b0;
      if (!stat_q[ST_BUSY] && !ctrl_q[CT_STB]) begin
        if (stat_q[ST_ACK]) begin
          stat_d[ST_ACK] = 1'b0;
        end else begin
          stat_d[ST_ACK]  = 1'b1;
          stat_d[ST_BUSY] = 1'b1;
        end
      end
    end
    stat_en = acc.wr_ctrl | acc.rd_stat;
    irq_d   = pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= STAT_RST;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (stat_en) begin
        stat_q <= stat_d;
        pend_q <= pend_d;
      end
      if (acc.any) irq_q <= irq_d;
    end
  end

  AST_INIT_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr_ctrl && !wdata[2]) |=> stat_q == 8'hD8); // R3
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc.rd_stat |=> !irq_q); // R6
  AST_NO_PEND_WITHOUT_IEN: assert property (@(posedge clk) disable iff (!rst_n)
    (acc.wr_ctrl && !ctrl_q[4] && !irq_q) |=> !irq_q); // R5
endmodule

// File: rtl/lpt_out_stream.sv
module lpt_out_stream
  import lpt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [BYTE_W-1:0] push_data,
  input  logic              ready,
  output logic              valid_q,
  output logic [BYTE_W-1:0] data_q,
  output logic              ovf_q
);
  logic              stall;
  logic              valid_d, ovf_d, data_en;

  always_comb begin
    stall   = valid_q & ~ready;
    data_en = push & ~stall;
    ovf_d   = ovf_q | (push & stall);
    if (data_en)        valid_d = 1'b1;
    else if (ready)     valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
      ovf_q   <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ovf_q   <= ovf_d;
      if (data_en) data_q <= push_data;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && !ready) |=> (valid_q && $stable(data_q))); // R10
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q); // R10
endmodule

// File: rtl/lpt_regif.sv
module lpt_regif
  import lpt_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  input  logic              rx_load,
  input  logic [7:0]        rx_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              overflow
);
  logic [1:0]        rst_sync;
  logic              rst_i;
  logic [OFS_W-1:0]  ofs;
  acc_t              acc;
  logic [BYTE_W-1:0] ctrl_q, dataw_q, datar_q, stat_q;
  logic              emit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  lpt_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd), .ofs(ofs), .acc(acc)
  );

  lpt_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_i), .acc(acc), .wdata(bus_wdata),
    .rx_load(rx_load), .rx_byte(rx_byte),
    .ctrl_q(ctrl_q), .dataw_q(dataw_q), .datar_q(datar_q), .emit(emit)
  );

  lpt_status_hs u_stat (
    .clk(clk), .rst_n(rst_i), .acc(acc), .wdata(bus_wdata),
    .ctrl_q(ctrl_q), .stat_q(stat_q), .irq_q(irq)
  );

  lpt_out_stream u_out (
    .clk(clk), .rst_n(rst_i), .push(emit), .push_data(dataw_q),
    .ready(out_ready), .valid_q(out_valid), .data_q(out_data), .ovf_q(overflow)
  );

  always_comb begin
    unique case (ofs)
      OFS_DATA: bus_rdata = ctrl_q[CT_DIR] ? datar_q : dataw_q;
      OFS_STAT: bus_rdata = stat_q;
      OFS_CTRL: bus_rdata = ctrl_q;
      default:  bus_rdata = OPEN_READ;
    endcase
  end

  AST_OPEN_OFFSET: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_rd && bus_addr[2:0] > 3'd2) |-> bus_rdata == 8'hFF); // R1
  AST_CTRL_HIGH_BITS: assert property (@(posedge clk) disable iff (!rst_i)
    (bus_rd && bus_addr[2:0] == 3'd2) |-> bus_rdata[7:6] == 2'b11); // R2
endmodule

// File: tb/lpt_regif_test.sv
module lpt_regif_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr, bus_wdata, rx_byte;
  logic       bus_wr, bus_rd, rx_load, out_ready;
  logic [7:0] bus_rdata, out_data;
  logic       irq, out_valid, overflow;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_dw, m_dr, m_st, m_ct, m_dat;
  bit         m_pend, m_irq, m_val, m_ovf;
  byte        sent_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  lpt_regif #(.ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .rx_load(rx_load), .rx_byte(rx_byte), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .overflow(overflow)
  );

  task automatic check(string tag, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] m_read(logic [2:0] o);
    case (o)
      3'd0: return m_ct[5] ? m_dr : m_dw;
      3'd1: return m_st;
      3'd2: return m_ct;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic step(bit w, bit r, logic [7:0] a, logic [7:0] d, bit rdy,
                      bit rl, logic [7:0] rb, string tag);
    logic [7:0] n_dw, n_dr, n_st, n_ct;
    bit n_pend, n_irq, n_val, n_ovf, fire, known, rd_only;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    out_ready = rdy; rx_load = rl; rx_byte = rb;
    #1;
    check(tag, "irq", {7'd0, irq}, {7'd0, m_irq});
    check(tag, "out_valid", {7'd0, out_valid}, {7'd0, m_val});
    check(tag, "overflow", {7'd0, overflow}, {7'd0, m_ovf});
    if (m_val) check(tag, "out_data", out_data, m_dat);
    rd_only = r && !w;
    if (rd_only) check(tag, "rdata", bus_rdata, m_read(a[2:0]));
    // behavioural next state
    n_dw = m_dw; n_dr = m_dr; n_st = m_st; n_ct = m_ct;
    n_pend = m_pend; n_irq = m_irq; n_val = m_val; n_ovf = m_ovf; fire = 0;
    known = a[2:0] <= 3'd2;
    if (rl) n_dr = rb;
    if (w && a[2:0] == 3'd0) n_dw = d;
    if (w && a[2:0] == 3'd2) begin
      n_ct = d | 8'hC0;
      if (d[2] == 1'b0) n_st = 8'hD8;
      else if (d[3]) begin
        if (d[0]) begin
          n_st[7] = 1'b0;
          fire = (m_ct[0] == 1'b0);
        end else if (m_ct[4]) n_pend = 1;
      end
    end
    if (rd_only && a[2:0] == 3'd1) begin
      n_pend = 0;
      if (!m_st[7] && !m_ct[0]) begin
        if (m_st[6]) n_st[6] = 1'b0;
        else begin n_st[6] = 1'b1; n_st[7] = 1'b1; end
      end
    end
    if ((w || rd_only) && known) n_irq = n_pend;
    if (m_val && rdy) begin n_val = 0; sent_q.push_back(m_dat); end
    if (fire) begin
      if (m_val && !rdy) n_ovf = 1;
      else begin n_val = 1; m_dat = m_dw; end
    end
    @(posedge clk);
    m_dw = n_dw; m_dr = n_dr; m_st = n_st; m_ct = n_ct;
    m_pend = n_pend; m_irq = n_irq; m_val = n_val; m_ovf = n_ovf;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual %h expected %h", 8'h01, 8'h00);
    finish_up();
  end

  initial begin
    rst_n = 0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_wdata = 0;
    out_ready = 0; rx_load = 0; rx_byte = 0;
    m_dw = 8'hFF; m_dr = 8'hFF; m_st = 8'hD9; m_ct = 8'hCC; m_dat = 8'h00;
    m_pend = 0; m_irq = 0; m_val = 0; m_ovf = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R9 reset values
    step(0, 0, 8'h00, 8'h00, 0, 0, 8'h00, "R9");
    step(0, 1, 8'h00, 8'h00, 0, 0, 8'h00, "R9");
    step(0, 1, 8'h02, 8'h00, 0, 0, 8'h00, "R9");
    step(0, 1, 8'h01, 8'h00, 0, 0, 8'h00, "R9");
    // R8 data latches, R11 incoming capture
    step(1, 0, 8'h00, 8'h41, 0, 0, 8'h00, "R8");
    step(0, 1, 8'h00, 8'h00, 0, 1, 8'h5A, "R11");
    step(1, 0, 8'h02, 8'h2C, 0, 0, 8'h00, "R2");
    step(0, 1, 8'h00, 8'h00, 0, 0, 8'h00, "R8");
    step(0, 1, 8'h02, 8'h00, 0, 0, 8'h00, "R2");
    // R4 strobe edge emits, consumer stalled
    step(1, 0, 8'h02, 8'h0D, 0, 0, 8'h00, "R4");
    step(0, 1, 8'h01, 8'h00, 0, 0, 8'h00, "R4");
    step(1, 0, 8'h02, 8'h0C, 0, 0, 8'h00, "R5");
    step(1, 0, 8'h00, 8'h77, 0, 0, 8'h00, "R8");
    step(1, 0, 8'h02, 8'h1D, 0, 0, 8'h00, "R10");
    step(1, 0, 8'h02, 8'h1C, 0, 0, 8'h00, "R5");
    // R6 R7 handshake polling
    step(0, 1, 8'h01, 8'h00, 0, 0, 8'h00, "R6");
    step(0, 1, 8'h01, 8'h00, 0, 0, 8'h00, "R7");
    step(0, 1, 8'h01, 8'h00, 0, 0, 8'h00, "R7");
    step(0, 0, 8'h00, 8'h00, 1, 0, 8'h00, "R10");
    // second emission accepted while consumer ready
    step(1, 0, 8'h02, 8'h1D, 1, 0, 8'h00, "R4");
    step(0, 0, 8'h00, 8'h00, 1, 0, 8'h00, "R10");
    step(1, 0, 8'h02, 8'h1D, 0, 0, 8'h00, "R4");
    // R1 aliasing and ignored offsets
    step(1, 0, 8'h0A, 8'h00, 0, 0, 8'h00, "R3");
    step(0, 1, 8'h0B, 8'h00, 0, 0, 8'h00, "R1");
    step(0, 1, 8'hFE, 8'h00, 0, 0, 8'h00, "R1");
    step(1, 0, 8'h03, 8'h55, 0, 0, 8'h00, "R1");
    step(1, 0, 8'h01, 8'h00, 0, 0, 8'h00, "R1");
    step(0, 1, 8'h01, 8'h00, 0, 0, 8'h00, "R1");
    step(0, 1, 8'h02, 8'h00, 0, 0, 8'h00, "R1");
    // R12 simultaneous read and write
    step(1, 1, 8'h02, 8'h1C, 0, 0, 8'h00, "R12");
    step(1, 1, 8'h02, 8'h1F, 0, 0, 8'h00, "R12");
    step(0, 1, 8'h01, 8'h00, 0, 0, 8'h00, "R12");
    step(0, 1, 8'h02, 8'h00, 1, 0, 8'h00, "R12");
    step(0, 0, 8'h00, 8'h00, 0, 0, 8'h00, "R10");
    // bytes delivered to the consumer in order
    n_chk++;
    if (sent_q.size() != 3 || sent_q[0] != 8'h41 || sent_q[1] != 8'h77) begin
      n_fail++;
      $display("FAIL R10 delivered count actual %0d expected %0d", sent_q.size(), 3);
    end
    finish_up();
  end
endmodule